// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Receiver with Error Classification

This block takes one logical channel of bit-serial HDLC traffic, one bit per cycle in which the valid strobe is high, and turns it into a byte stream. It finds the opening and closing flags, removes the zero bits that the transmitter inserted after runs of five ones, and packs the remaining bits into octets, least significant bit first. Every received byte is passed on, including the two check bytes at the end of the frame. The first byte of a frame carries a start marker.

When a frame closes, the block raises an end strobe together with a 32-bit status word. The word holds the channel's connection number and a separate flag for each way a frame can go wrong: a failed check sequence, too few bytes, too many bytes, an abort, or a closing flag that does not fall on an octet boundary. A further bit marks the first frame that finishes after the channel was configured. A one-cycle configure pulse loads the connection number and puts the receiver back into flag search.

Top module: `hdlc_rx_channel`

## Requirements
- R1: While reset is held and after it is released, with no input activity, `o_byte_vld` and `o_end` are 0 and `o_status` is 0.
- R2: Idle flags, back-to-back flags and a flag followed by an abort produce no byte and no end strobe.
- R3: The bits between an opening and a closing flag (flag pattern 0x7E), with every 0 that follows five consecutive 1s deleted, appear on `o_byte` least significant bit first. `o_sof` is high with the first byte of each frame only.
- R4: The check over a frame is the reflected CRC-16 with polynomial 0x8408 and preset 0xFFFF, run over all received bytes including the two check bytes. Status bit 24 is set when the final register differs from 0xF0B8. The check bytes still appear on `o_byte`.
- R5: Status bit 25 is set when a closed frame has fewer than 5 bytes, check bytes counted. A frame of exactly 5 bytes does not set it.
- R6: Status bit 26 is set when a closed frame has more than 2047 bytes. A frame of exactly 2047 bytes does not set it.
- R7: Seven consecutive 1s abort an open frame. The bytes already complete are passed on, then an end strobe follows with status bit 27 set and bits 24, 25, 26 and 28 clear. Input is ignored until the next flag.
- R8: Status bit 28 is set when the bit count between the flags, after zero deletion, is not a multiple of 8. The partial bits are dropped.
- R9: Status bits 9:0 carry the connection number latched from `cfg_conn` on the last `cfg_load` pulse.
- R10: Status bit 29 is set on the first end strobe after a `cfg_load` pulse and clear on the following ones.
- R11: Status bits 31:30 and 23:10 are always 0 with an end strobe.
- R12: `o_end` is high in the clock cycle right after the edge that samples the last bit of the closing flag (or the seventh 1 of an abort).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial line bit |
| bit_vld | input | 1 | `bit_in` is taken in this cycle |
| cfg_load | input | 1 | Configure pulse: latch connection number, restart flag search |
| cfg_conn | input | 10 | Connection number (0 to 511 in use) |
| o_byte | output | 8 | Received octet |
| o_byte_vld | output | 1 | `o_byte` is valid |
| o_sof | output | 1 | First byte of a frame |
| o_end | output | 1 | Frame end strobe; `o_status` valid |
| o_status | output | 32 | Frame status word |

## Verification
Every output is registered once after the edge that takes in the deciding bit, so the end strobe and status are due on the sampling point one cycle after the last bit of the closing flag or of the abort run. A received byte appears eight line bits later than its last bit arrived, because the flag window delays the stream. The bench drives each bit on a falling edge and checks `o_end` on the very next falling edge after the final flag bit. Byte content and the status word are collected by a falling-edge monitor and compared a few cycles later, once the frame has closed.

// File: rtl/hdlc_rx_pkg.sv
`timescale 1ns/1ps
package hdlc_rx_pkg;
  localparam int CONN_W   = 10;
  localparam int ST_FCS   = 24;
  localparam int ST_SHORT = 25;
  localparam int ST_LONG  = 26;
  localparam int ST_ABORT = 27;
  localparam int ST_OCTET = 28;
  localparam int ST_FIRST = 29;
  localparam logic [31:0] ST_RSV_MASK = 32'hC0FF_FC00;
  localparam logic [7:0]  FLAG_PAT    = 8'h7E;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R  = 16'h8408;
  localparam logic [15:0] CRC_GOOD    = 16'hF0B8;

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc_bit = fb ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
  endfunction
endpackage

// File: rtl/hdlc_rx_bitfront.sv
`timescale 1ns/1ps
module hdlc_rx_bitfront
  import hdlc_rx_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic bit_in,
  input  logic bit_vld,
  output logic d_vld,
  output logic d_bit,
  output logic flag_hit,
  output logic abort_hit
);
  localparam int FILL_W = $clog2(WIN_W + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(WIN_W);

  logic [WIN_W-1:0]  win_q, win_d, win_nx;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [2:0]        ones_q, ones_d;
  logic              hunt_q, hunt_d;
  logic              flag_c, abort_c, cand, stuffed;

  always_comb begin
    win_nx   = {bit_in, win_q[WIN_W-1:1]};
    flag_c   = bit_vld && (win_nx == FLAG_PAT);
    abort_c  = bit_vld && (&win_nx[WIN_W-1:1]);
    cand     = bit_vld && !hunt_q && (fill_q == FILL_FULL) && !abort_c;
    stuffed  = cand && !win_q[0] && (ones_q == 3'd5);
    d_vld    = cand && !stuffed;
    d_bit    = win_q[0];
    flag_hit = flag_c;
    abort_hit = abort_c && !hunt_q;

    win_d  = bit_vld ? win_nx : win_q;
    fill_d = fill_q;
    ones_d = ones_q;
    hunt_d = hunt_q;
    if (restart) begin
      fill_d = '0;
      ones_d = '0;
      hunt_d = 1'b1;
    end else begin
      if (flag_c) fill_d = '0;
      else if (bit_vld && fill_q != FILL_FULL) fill_d = fill_q + FILL_W'(1);
      if (flag_c) ones_d = '0;
      else if (cand) ones_d = win_q[0] ? ((ones_q == 3'd7) ? ones_q : ones_q + 3'd1) : 3'd0;
      if (abort_c) hunt_d = 1'b1;
      else if (flag_c) hunt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
      ones_q <= '0;
      hunt_q <= 1'b1;
    end else begin
      if (bit_vld || restart) begin
        win_q  <= win_d;
        fill_q <= fill_d;
        ones_q <= ones_d;
        hunt_q <= hunt_d;
      end
    end
  end

  // R3: a sixth one in a row never reaches the octet packer as data
  assert_no_sixth_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && d_bit) |-> (ones_q < 3'd5));
endmodule

// File: rtl/hdlc_rx_octet.sv
`timescale 1ns/1ps
module hdlc_rx_octet
  import hdlc_rx_pkg::*;
#(
  parameter int MAX_LEN = 2047,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CONN_W-1:0] cfg_conn,
  input  logic              d_vld,
  input  logic              d_bit,
  input  logic              flag_hit,
  input  logic              abort_hit,
  output logic [7:0]        o_byte,
  output logic              o_byte_vld,
  output logic              o_sof,
  output logic              o_end,
  output logic [31:0]       o_status
);
  localparam int NW = $clog2(MAX_LEN + 2);
  localparam logic [NW-1:0] MIN_N = NW'(MIN_LEN);
  localparam logic [NW-1:0] MAX_N = NW'(MAX_LEN);
  localparam logic [NW-1:0] SAT_N = NW'(MAX_LEN + 1);

  logic [7:0]        acc_q, acc_d, acc_a;
  logic [2:0]        bcnt_q, bcnt_d, bcnt_a;
  logic [15:0]       crc_q, crc_d, crc_a;
  logic [NW-1:0]     nb_q, nb_d, nb_a;
  logic [CONN_W-1:0] conn_q, conn_d;
  logic              first_q, first_d;
  logic [7:0]        byte_d;
  logic              bvld_d, sof_d, end_d;
  logic [31:0]       stat_d;
  logic              byte_done, adv;

  always_comb begin
    acc_a     = d_vld ? {d_bit, acc_q[7:1]} : acc_q;
    bcnt_a    = d_vld ? bcnt_q + 3'd1 : bcnt_q;
    crc_a     = d_vld ? crc_bit(crc_q, d_bit) : crc_q;
    byte_done = d_vld && (bcnt_q == 3'd7);
    nb_a      = (byte_done && nb_q != SAT_N) ? nb_q + NW'(1) : nb_q;
    adv       = d_vld || flag_hit || abort_hit || restart;

    acc_d   = acc_a;
    bcnt_d  = bcnt_a;
    crc_d   = crc_a;
    nb_d    = nb_a;
    conn_d  = conn_q;
    first_d = first_q;
    byte_d  = acc_a;
    bvld_d  = byte_done;
    sof_d   = byte_done && (nb_q == '0);
    end_d   = 1'b0;
    stat_d  = o_status;

    if (restart) begin
      bcnt_d  = '0;
      crc_d   = CRC_PRESET;
      nb_d    = '0;
      conn_d  = cfg_conn;
      first_d = 1'b1;
      bvld_d  = 1'b0;
      sof_d   = 1'b0;
    end else if (flag_hit || abort_hit) begin
      bcnt_d = '0;
      crc_d  = CRC_PRESET;
      nb_d   = '0;
      if (nb_a != '0) begin
        end_d            = 1'b1;
        first_d          = 1'b0;
        stat_d           = '0;
        stat_d[CONN_W-1:0] = conn_q;
        stat_d[ST_FIRST] = first_q;
        if (abort_hit) begin
          stat_d[ST_ABORT] = 1'b1;
        end else begin
          stat_d[ST_FCS]   = (crc_a != CRC_GOOD);
          stat_d[ST_SHORT] = (nb_a < MIN_N);
          stat_d[ST_LONG]  = (nb_a > MAX_N);
          stat_d[ST_OCTET] = (bcnt_a != 3'd0);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      bcnt_q     <= '0;
      crc_q      <= CRC_PRESET;
      nb_q       <= '0;
      conn_q     <= '0;
      first_q    <= 1'b0;
      o_byte     <= '0;
      o_byte_vld <= 1'b0;
      o_sof      <= 1'b0;
      o_end      <= 1'b0;
      o_status   <= '0;
    end else begin
      if (adv) begin
        acc_q   <= acc_d;
        bcnt_q  <= bcnt_d;
        crc_q   <= crc_d;
        nb_q    <= nb_d;
        conn_q  <= conn_d;
        first_q <= first_d;
      end
      if (bvld_d) o_byte <= byte_d;
      if (end_d)  o_status <= stat_d;
      o_byte_vld <= bvld_d;
      o_sof      <= sof_d;
      o_end      <= end_d;
    end
  end

  // Output-side frame tracker used by the checks below
  logic chk_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chk_open <= 1'b0;
    else if (o_end)      chk_open <= 1'b0;
    else if (o_byte_vld) chk_open <= 1'b1;
  end

  assert_sof_first_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    o_byte_vld |-> (o_sof == !chk_open));
  assert_no_empty_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    o_end |-> (chk_open || o_byte_vld));
  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    o_end |-> ((o_status & ST_RSV_MASK) == 32'h0));
  assert_abort_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_end && o_status[ST_ABORT]) |->
      !(o_status[ST_FCS] || o_status[ST_SHORT] || o_status[ST_LONG] || o_status[ST_OCTET]));
  assert_len_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    o_end |-> !(o_status[ST_SHORT] && o_status[ST_LONG]));
endmodule

// File: rtl/hdlc_rx_channel.sv
`timescale 1ns/1ps
module hdlc_rx_channel
  import hdlc_rx_pkg::*;
#(
  parameter int MAX_LEN = 2047,
  parameter int MIN_LEN = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_in,
  input  logic        bit_vld,
  input  logic        cfg_load,
  input  logic [9:0]  cfg_conn,
  output logic [7:0]  o_byte,
  output logic        o_byte_vld,
  output logic        o_sof,
  output logic        o_end,
  output logic [31:0] o_status
);
  logic d_vld, d_bit, flag_hit, abort_hit;

  hdlc_rx_bitfront #(.WIN_W(8)) front_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (cfg_load),
    .bit_in    (bit_in),
    .bit_vld   (bit_vld),
    .d_vld     (d_vld),
    .d_bit     (d_bit),
    .flag_hit  (flag_hit),
    .abort_hit (abort_hit)
  );

  hdlc_rx_octet #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) octet_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (cfg_load),
    .cfg_conn   (cfg_conn),
    .d_vld      (d_vld),
    .d_bit      (d_bit),
    .flag_hit   (flag_hit),
    .abort_hit  (abort_hit),
    .o_byte     (o_byte),
    .o_byte_vld (o_byte_vld),
    .o_sof      (o_sof),
    .o_end      (o_end),
    .o_status   (o_status)
  );

  // R12: an end strobe only follows a sampled line bit
  assert_end_after_bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    o_end |-> $past(bit_vld));
endmodule

// File: tb/hdlc_rx_channel_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_channel_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bit_in, bit_vld, cfg_load;
  logic [9:0]  cfg_conn;
  logic [7:0]  o_byte;
  logic        o_byte_vld, o_sof, o_end;
  logic [31:0] o_status;

  hdlc_rx_channel dut_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .cfg_load(cfg_load), .cfg_conn(cfg_conn), .o_byte(o_byte),
    .o_byte_vld(o_byte_vld), .o_sof(o_sof), .o_end(o_end), .o_status(o_status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errs   = 0;
  int sof_bad  = 0;
  bit gap_en   = 1'b0;
  bit first_exp = 1'b0;
  bit done     = 1'b0;
  int ones_run = 0;
  logic [9:0]  conn_exp = '0;
  logic [7:0]  tx_q[$];
  logic [7:0]  got_q[$];
  logic [31:0] st_q[$];
  localparam logic [31:0] MASK_ALL = 32'hFFFF_FFFF;
  localparam logic [31:0] MASK_NOFCS = 32'hFEFF_FFFF;

  always @(negedge clk) begin
    if (rst_n) begin
      if (o_byte_vld) begin
        got_q.push_back(o_byte);
        if (o_sof != (got_q.size() == 1)) sof_bad++;
      end
      if (o_end) st_q.push_back(o_status);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        c = ((c[0] ^ tx_q[i][k]) != 1'b0) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  function automatic logic [31:0] exp_status(input int n, input bit fcs_bad,
                                             input bit oct, input bit ab);
    logic [31:0] s;
    s = 32'h0;
    s[9:0] = conn_exp;
    s[29]  = first_exp;
    if (ab) s[27] = 1'b1;
    else begin
      s[24] = fcs_bad;
      s[25] = (n < 5);
      s[26] = (n > 2047);
      s[28] = oct;
    end
    return s;
  endfunction

  task automatic send_bit(input bit b);
    if (gap_en && $urandom_range(0, 3) == 0) @(negedge clk);
    bit_in  = b;
    bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_raw(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_stuffed(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i]);
      if (v[i]) begin
        ones_run++;
        if (ones_run == 5) begin
          send_bit(1'b0);
          ones_run = 0;
        end
      end else ones_run = 0;
    end
  endtask

  task automatic configure(input logic [9:0] c);
    cfg_conn = c;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    conn_exp  = c;
    first_exp = 1'b1;
  endtask

  // tx_q holds the payload; optional check bytes, corruption, trailing bits
  task automatic send_frame(input bit add_fcs, input bit corrupt, input int extra);
    logic [15:0] c;
    if (add_fcs) begin
      c = ~crc_of(tx_q.size());
      tx_q.push_back(c[7:0]);
      tx_q.push_back(c[15:8]);
    end
    if (corrupt) tx_q[tx_q.size()-1] = tx_q[tx_q.size()-1] ^ 8'h10;
    send_raw(8'h7E);
    ones_run = 0;
    foreach (tx_q[i]) send_stuffed(tx_q[i]);
    for (int i = 0; i < extra; i++) send_bit(1'b0);
    send_raw(8'h7E);
    // R12: end strobe is due on this sampling point
    chk(o_end === 1'b1, "R12", "end strobe timing", {31'h0, o_end}, 32'h1);
  endtask

  task automatic check_frame(input int nb, input logic [31:0] est,
                             input logic [31:0] mask, input string req);
    bit ok;
    repeat (3) @(negedge clk);
    ok = (got_q.size() == nb) && (sof_bad == 0);
    for (int i = 0; i < nb; i++)
      if (ok && got_q[i] !== tx_q[i]) ok = 1'b0;
    chk(ok, req, "bytes", got_q.size(), nb);
    chk((st_q.size() == 1) && (((st_q[0] ^ est) & mask) == 32'h0), req, "status",
        (st_q.size() != 0) ? st_q[0] : 32'hDEAD_DEAD, est);
    got_q.delete();
    st_q.delete();
    sof_bad   = 0;
    first_exp = 1'b0;
  endtask

  task automatic check_silent(input string req);
    repeat (3) @(negedge clk);
    chk(got_q.size() == 0 && st_q.size() == 0, req, "no output",
        got_q.size() + st_q.size(), 0);
    got_q.delete();
    st_q.delete();
  endtask

  task automatic fill_payload(input int n);
    int r;
    tx_q.delete();
    for (int i = 0; i < n; i++) begin
      r = $urandom_range(0, 5);
      if (r < 2)       tx_q.push_back(8'hFF);
      else if (r == 2) tx_q.push_back(8'h7E);
      else             tx_q.push_back(8'($urandom));
    end
  endtask

  initial begin
    #3_000_000;
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    int len;
    bit bad;
    void'($urandom(32'd4242));
    rst_n = 1'b0; bit_in = 1'b0; bit_vld = 1'b0; cfg_load = 1'b0; cfg_conn = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(o_byte_vld === 1'b0 && o_end === 1'b0 && o_status === 32'h0, "R1", "reset outputs",
        o_status, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(o_byte_vld === 1'b0 && o_end === 1'b0 && o_status === 32'h0, "R1", "after release",
        o_status, 32'h0);

    configure(10'd5);
    // R2: idle and back-to-back flags
    for (int i = 0; i < 6; i++) send_raw(8'h7E);
    check_silent("R2");

    // R3 R4 R9 R10: first good frame after configure
    fill_payload(10);
    send_frame(1'b1, 1'b0, 0);
    check_frame(12, exp_status(12, 1'b0, 1'b0, 1'b0), MASK_ALL, "R3 R4 R9 R10 first");
    // R10: second frame has the first-record bit clear
    fill_payload(7);
    send_frame(1'b1, 1'b0, 0);
    check_frame(9, exp_status(9, 1'b0, 1'b0, 1'b0), MASK_ALL, "R10 second");

    // R4: corrupted check bytes
    fill_payload(12);
    send_frame(1'b1, 1'b1, 0);
    check_frame(14, exp_status(14, 1'b1, 1'b0, 1'b0), MASK_ALL, "R4 bad fcs");

    // R5: boundary at 4 and 5 bytes
    fill_payload(2);
    send_frame(1'b1, 1'b0, 0);
    check_frame(4, exp_status(4, 1'b0, 1'b0, 1'b0), MASK_ALL, "R5 four bytes");
    fill_payload(3);
    send_frame(1'b1, 1'b0, 0);
    check_frame(5, exp_status(5, 1'b0, 1'b0, 1'b0), MASK_ALL, "R5 five bytes");

    // R8: three trailing bits before the closing flag
    fill_payload(8);
    send_frame(1'b1, 1'b0, 3);
    check_frame(10, exp_status(10, 1'b0, 1'b1, 1'b0), MASK_NOFCS, "R8 misaligned");

    // R7: abort after six bytes; the last byte is only partly passed
    gap_en = 1'b1;
    fill_payload(5);
    tx_q.push_back(8'h00);
    send_raw(8'h7E);
    ones_run = 0;
    foreach (tx_q[i]) send_stuffed(tx_q[i]);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    chk(o_end === 1'b1, "R12", "abort strobe timing", {31'h0, o_end}, 32'h1);
    send_bit(1'b1);
    check_frame(5, exp_status(5, 1'b0, 1'b0, 1'b1), MASK_ALL, "R7 abort");
    // R7: junk after abort is ignored until the next flag
    send_raw(8'hA5);
    send_raw(8'h3C);
    check_silent("R7 hunt");
    // R2: flag followed at once by an abort
    send_raw(8'h7E);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    check_silent("R2 empty abort");
    fill_payload(6);
    send_frame(1'b1, 1'b0, 0);
    check_frame(8, exp_status(8, 1'b0, 1'b0, 1'b0), MASK_ALL, "R7 recovery");

    // R9 R10: reconfigure with the top connection number
    configure(10'd511);
    fill_payload(9);
    send_frame(1'b1, 1'b0, 0);
    check_frame(11, exp_status(11, 1'b0, 1'b0, 1'b0), MASK_ALL, "R9 R10 reconfig");

    // R3 R4 R5 R11: random frames
    for (int f = 0; f < 24; f++) begin
      len = $urandom_range(1, 40);
      bad = ($urandom_range(0, 4) == 0);
      fill_payload(len);
      send_frame(1'b1, bad, 0);
      check_frame(len + 2, exp_status(len + 2, bad, 1'b0, 1'b0), MASK_ALL, "R3 R4 R5 R11 random");
      if ($urandom_range(0, 2) == 0) begin
        send_raw(8'h7E);
        check_silent("R2 random idle");
      end
    end

    // R6: boundary at 2047 and 2048 bytes
    gap_en = 1'b0;
    tx_q.delete();
    for (int i = 0; i < 2045; i++) tx_q.push_back(8'($urandom));
    send_frame(1'b1, 1'b0, 0);
    check_frame(2047, exp_status(2047, 1'b0, 1'b0, 1'b0), MASK_ALL, "R6 2047 bytes");
    tx_q.delete();
    for (int i = 0; i < 2046; i++) tx_q.push_back(8'($urandom));
    send_frame(1'b1, 1'b0, 0);
    check_frame(2048, exp_status(2048, 1'b0, 1'b0, 1'b0), MASK_ALL, "R6 2048 bytes");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule